// File: doc/BRIEF.md
# Prioritized Interrupt Request and Vector Unit

This block takes in a set of interrupt request lines, keeps track of which requests are pending and which are being serviced, and works out which request should interrupt the processor. Each request line is captured on a rising edge or followed by level, depending on a configuration input. A per-line mask input keeps a pending request from raising the interrupt output. Line 0 has the highest priority and priority falls as the line number rises.

The processor answers the interrupt output with two acknowledge pulses. The first pulse fixes the winning level, marks it as in service and leaves the data bus undriven. The second pulse drives a vector byte onto the bus. The upper bits of that byte are a programmed base and the lower bits are the level number. When service ends, the in-service mark is removed in one of two ways. If automatic end-of-interrupt is enabled, the block removes it when the second pulse ends. Otherwise software sends a non-specific end-of-interrupt strobe, which clears the most urgent in-service level.

All configuration (trigger mode, vector base, automatic end-of-interrupt) comes in on plain input ports. The reset is synchronous and active high.

Top module: `irq_vector_unit`

## Requirements
- R1: While reset is high, the pending register, the in-service register, `int_req` and `data_oe` are all cleared to zero at the next clock edge.
- R2: With `level_mode` low, a low-to-high change on `irq_lines[i]` sets pending bit i one clock later. Once that bit has been cleared, the line must go low and then high again before the bit can be set again.
- R3: With `level_mode` high, the pending register copies `irq_lines` on every clock edge. Moving a level into service does not clear its pending bit.
- R4: `int_req` is high only when the handshake is idle and some pending bit whose `irq_mask` bit is 0 is more urgent than every in-service level. A pending bit that is masked never raises `int_req`.
- R5: Among eligible requests, the lowest line index wins. Line 0 is the most urgent.
- R6: The rising edge of the first acknowledge pulse sets the in-service bit of the winner. In edge mode the same edge also clears that level's pending bit. `data_oe` stays low during the first pulse and during the gap between the pulses.
- R7: From the start of the second acknowledge pulse until it ends, `data_oe` is high and `data_out` holds a steady value: bits [7:3] are `vec_base` and bits [2:0] are the winning level (for example, level 6 gives 110).
- R8: With `auto_eoi` high, the in-service bit of the acknowledged level is cleared on the clock edge where `ack` is first seen low after the second pulse, and `data_oe` drops on that same edge.
- R9: With `auto_eoi` low, an in-service bit stays set until `eoi_strobe` is pulsed. Each strobe clears only the lowest-index in-service bit.
- R10: Nesting follows priority. While a level is in service, a new request of higher priority raises `int_req`, and a request of the same or lower priority does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 8 | Request lines, line 0 most urgent |
| irq_mask | input | 8 | 1 keeps that line from raising `int_req` |
| level_mode | input | 1 | 1 = pending bits follow the line level, 0 = rising-edge capture |
| auto_eoi | input | 1 | 1 = clear the in-service bit when the second acknowledge ends |
| vec_base | input | 5 | Upper bits of the returned vector |
| eoi_strobe | input | 1 | One-cycle non-specific end-of-interrupt |
| ack | input | 1 | Acknowledge pulses, active high |
| int_req | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Vector byte |
| data_oe | output | 1 | High while `data_out` is driven |
| irr_q | output | 8 | Pending register contents |
| isr_q | output | 8 | In-service register contents |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- The pending register copies the lines in level mode.
- In edge mode, a pending bit can only appear after its line was high.
- `int_req` needs an unmasked pending bit and stays low while the vector is driven.
- The vector holds steady for the whole second pulse.
- At most one in-service bit is set per edge.
- In-service bits are never lost without an end-of-interrupt.

Other behaviour depends on ordered stimulus, and only the bench scenarios can show it:
- The exact vector value returned.
- The choice of winner between simultaneous requests.
- Nesting against an in-service level.
- Which bit an end-of-interrupt strobe removes.
- The need for a fresh edge before a line can be captured again.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int unsigned IRQ_N_DEF = 8;
    localparam int unsigned VEC_W_DEF = 8;

    // Acknowledge handshake phases
    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_FIRST  = 2'd1,
        HS_GAP    = 2'd2,
        HS_SECOND = 2'd3
    } hs_state_e;

    // Index of the lowest set bit among the first n bits of v; n when none is set.
    function automatic int unsigned lowest_set(input logic [31:0] v, input int unsigned n);
        int unsigned r;
        r = n;
        for (int i = 31; i >= 0; i--) begin
            if ((i < int'(n)) && v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/irqv_req_reg.sv
module irqv_req_reg #(
    parameter int N_LINES = irqv_pkg::IRQ_N_DEF,
    localparam int LVL_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               level_mode,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               clr_en,
    input  logic [LVL_W-1:0]   clr_lvl,
    output logic [N_LINES-1:0] irr
);
    logic [N_LINES-1:0] line_prev;
    logic [N_LINES-1:0] clr_hit;
    logic [N_LINES-1:0] rise;

    for (genvar i = 0; i < N_LINES; i++) begin : g_bit
        assign clr_hit[i] = clr_en && (clr_lvl == LVL_W'(i));
        assign rise[i]    = irq_lines[i] && !line_prev[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr       <= '0;
            line_prev <= '0;
        end else begin
            line_prev <= irq_lines;
            if (level_mode) begin
                irr <= irq_lines;
            end else begin
                irr <= (irr & ~clr_hit) | rise;
            end
        end
    end
endmodule

// File: rtl/irqv_resolver.sv
module irqv_resolver #(
    parameter int N_LINES = irqv_pkg::IRQ_N_DEF,
    localparam int LVL_W = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] irr,
    input  logic [N_LINES-1:0] isr,
    input  logic [N_LINES-1:0] mask,
    output logic               eligible,
    output logic [LVL_W-1:0]   win_lvl,
    output logic               svc_valid,
    output logic [LVL_W-1:0]   svc_lvl
);
    import irqv_pkg::*;

    int unsigned pend_idx;
    int unsigned svc_idx;

    always_comb begin
        pend_idx  = lowest_set(32'(irr & ~mask), N_LINES);
        svc_idx   = lowest_set(32'(isr), N_LINES);
        eligible  = pend_idx < svc_idx;
        win_lvl   = LVL_W'(pend_idx);
        svc_valid = svc_idx < N_LINES;
        svc_lvl   = LVL_W'(svc_idx);
    end
endmodule

// File: rtl/irqv_isr_reg.sv
module irqv_isr_reg #(
    parameter int N_LINES = irqv_pkg::IRQ_N_DEF,
    localparam int LVL_W = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [LVL_W-1:0]   set_lvl,
    input  logic               aeoi_en,
    input  logic [LVL_W-1:0]   aeoi_lvl,
    input  logic               eoi_en,
    input  logic [LVL_W-1:0]   eoi_lvl,
    output logic [N_LINES-1:0] isr
);
    logic [N_LINES-1:0] set_hit, aeoi_hit, eoi_hit;

    for (genvar i = 0; i < N_LINES; i++) begin : g_bit
        assign set_hit[i]  = set_en  && (set_lvl  == LVL_W'(i));
        assign aeoi_hit[i] = aeoi_en && (aeoi_lvl == LVL_W'(i));
        assign eoi_hit[i]  = eoi_en  && (eoi_lvl  == LVL_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr <= '0;
        end else begin
            isr <= (isr & ~(aeoi_hit | eoi_hit)) | set_hit;
        end
    end
endmodule

// File: rtl/irqv_ack_fsm.sv
module irqv_ack_fsm #(
    parameter int N_LINES = irqv_pkg::IRQ_N_DEF,
    parameter int VEC_W   = irqv_pkg::VEC_W_DEF,
    localparam int LVL_W  = $clog2(N_LINES),
    localparam int BASE_W = VEC_W - LVL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack,
    input  logic              eligible,
    input  logic [LVL_W-1:0]  win_lvl,
    input  logic [BASE_W-1:0] vec_base,
    input  logic              auto_eoi,
    output logic              set_en,
    output logic [LVL_W-1:0]  set_lvl,
    output logic              aeoi_en,
    output logic [LVL_W-1:0]  aeoi_lvl,
    output logic              hs_idle,
    output logic [VEC_W-1:0]  data_out,
    output logic              data_oe
);
    import irqv_pkg::*;

    hs_state_e        state;
    logic [LVL_W-1:0] sel_lvl;
    logic             sel_ok;

    assign hs_idle  = (state == HS_IDLE);
    assign set_en   = hs_idle && ack && eligible;
    assign set_lvl  = win_lvl;
    assign aeoi_en  = (state == HS_SECOND) && !ack && auto_eoi && sel_ok;
    assign aeoi_lvl = sel_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= HS_IDLE;
            sel_lvl  <= '0;
            sel_ok   <= 1'b0;
            data_out <= '0;
            data_oe  <= 1'b0;
        end else begin
            unique case (state)
                HS_IDLE: if (ack) begin
                    sel_lvl <= eligible ? win_lvl : LVL_W'(N_LINES - 1);
                    sel_ok  <= eligible;
                    state   <= HS_FIRST;
                end
                HS_FIRST: if (!ack) state <= HS_GAP;
                HS_GAP: if (ack) begin
                    data_out <= {vec_base, sel_lvl};
                    data_oe  <= 1'b1;
                    state    <= HS_SECOND;
                end
                HS_SECOND: if (!ack) begin
                    data_oe <= 1'b0;
                    sel_ok  <= 1'b0;
                    state   <= HS_IDLE;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
    parameter int N_LINES = irqv_pkg::IRQ_N_DEF,
    parameter int VEC_W   = irqv_pkg::VEC_W_DEF,
    localparam int LVL_W  = $clog2(N_LINES),
    localparam int BASE_W = VEC_W - LVL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic [N_LINES-1:0] irq_mask,
    input  logic               level_mode,
    input  logic               auto_eoi,
    input  logic [BASE_W-1:0]  vec_base,
    input  logic               eoi_strobe,
    input  logic               ack,
    output logic               int_req,
    output logic [VEC_W-1:0]   data_out,
    output logic               data_oe,
    output logic [N_LINES-1:0] irr_q,
    output logic [N_LINES-1:0] isr_q
);
    logic             eligible, svc_valid, hs_idle;
    logic [LVL_W-1:0] win_lvl, svc_lvl;
    logic             set_en, aeoi_en;
    logic [LVL_W-1:0] set_lvl, aeoi_lvl;

    irqv_req_reg #(.N_LINES(N_LINES)) req_i (
        .clk(clk), .rst(rst), .level_mode(level_mode), .irq_lines(irq_lines),
        .clr_en(set_en), .clr_lvl(set_lvl), .irr(irr_q)
    );

    irqv_resolver #(.N_LINES(N_LINES)) res_i (
        .irr(irr_q), .isr(isr_q), .mask(irq_mask),
        .eligible(eligible), .win_lvl(win_lvl),
        .svc_valid(svc_valid), .svc_lvl(svc_lvl)
    );

    irqv_isr_reg #(.N_LINES(N_LINES)) isr_i (
        .clk(clk), .rst(rst),
        .set_en(set_en), .set_lvl(set_lvl),
        .aeoi_en(aeoi_en), .aeoi_lvl(aeoi_lvl),
        .eoi_en(eoi_strobe && svc_valid), .eoi_lvl(svc_lvl),
        .isr(isr_q)
    );

    irqv_ack_fsm #(.N_LINES(N_LINES), .VEC_W(VEC_W)) fsm_i (
        .clk(clk), .rst(rst), .ack(ack), .eligible(eligible), .win_lvl(win_lvl),
        .vec_base(vec_base), .auto_eoi(auto_eoi),
        .set_en(set_en), .set_lvl(set_lvl), .aeoi_en(aeoi_en), .aeoi_lvl(aeoi_lvl),
        .hs_idle(hs_idle), .data_out(data_out), .data_oe(data_oe)
    );

    assign int_req = eligible && hs_idle;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
    parameter int N_LINES = irqv_pkg::IRQ_N_DEF,
    parameter int VEC_W   = irqv_pkg::VEC_W_DEF,
    localparam int LVL_W  = $clog2(N_LINES),
    localparam int BASE_W = VEC_W - LVL_W
) (
    input logic               clk,
    input logic               rst,
    input logic [N_LINES-1:0] irq_lines,
    input logic [N_LINES-1:0] irq_mask,
    input logic               level_mode,
    input logic               auto_eoi,
    input logic [BASE_W-1:0]  vec_base,
    input logic               eoi_strobe,
    input logic               ack,
    input logic               int_req,
    input logic [VEC_W-1:0]   data_out,
    input logic               data_oe,
    input logic [N_LINES-1:0] irr_q,
    input logic [N_LINES-1:0] isr_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (isr_q == '0 && irr_q == '0 && !data_oe));

    // R2
    edge_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !level_mode |=> ((irr_q & ~$past(irr_q) & ~$past(irq_lines)) == '0));

    // R3
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        level_mode |=> (irr_q == $past(irq_lines)));

    // R4
    req_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        int_req |-> ((irr_q & ~irq_mask) != '0 && !data_oe));

    // R6
    single_entry_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(isr_q) <= $countones($past(isr_q)) + 1));

    // R7
    vector_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_oe && ack) |=> (data_oe && $stable(data_out)));

    // R8
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        (data_oe && !ack) |=> !data_oe);

    // R9
    isr_retain_chk: assert property (@(posedge clk) disable iff (rst)
        (!auto_eoi && !eoi_strobe) |=> ((isr_q & $past(isr_q)) == $past(isr_q)));

    // R9
    eoi_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_strobe && !ack && isr_q != '0) |=> ($countones(isr_q) < $countones($past(isr_q))));
endmodule

bind irq_vector_unit irqv_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) chk_i (.*);

// File: tb/irq_vector_unit_tb_top.sv
`timescale 1ns/1ps
module irq_vector_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_lines, irq_mask;
    logic       level_mode, auto_eoi, eoi_strobe, ack;
    logic [4:0] vec_base;
    logic       int_req, data_oe;
    logic [7:0] data_out, irr_q, isr_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_unit dut_i (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .irq_mask(irq_mask),
        .level_mode(level_mode), .auto_eoi(auto_eoi), .vec_base(vec_base),
        .eoi_strobe(eoi_strobe), .ack(ack), .int_req(int_req),
        .data_out(data_out), .data_oe(data_oe), .irr_q(irr_q), .isr_q(isr_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // First acknowledge pulse; checks ISR/IRR after its leading edge
    task automatic ack_first(input string tag, input logic [7:0] exp_isr, input logic [7:0] exp_irr);
        ack = 1'b1; cyc(1);
        check({tag, " R6 isr after ack1"}, isr_q, exp_isr);
        check({tag, " R6 irr after ack1"}, irr_q, exp_irr);
        check({tag, " R6 bus idle ack1"}, data_oe, 1'b0);
        ack = 1'b0; cyc(1);
        check({tag, " R6 bus idle gap"}, data_oe, 1'b0);
    endtask

    // Second acknowledge pulse; checks vector and ISR after its end
    task automatic ack_second(input string tag, input logic [7:0] exp_vec, input logic [7:0] exp_isr_end);
        ack = 1'b1; cyc(1);
        check({tag, " R7 oe"}, data_oe, 1'b1);
        check({tag, " R7 vector"}, data_out, exp_vec);
        cyc(1);
        check({tag, " R7 vector held"}, data_out, exp_vec);
        ack = 1'b0; cyc(1);
        check({tag, " R8 oe released"}, data_oe, 1'b0);
        check({tag, " R8/R9 isr after ack2"}, isr_q, exp_isr_end);
    endtask

    task automatic pulse_eoi();
        eoi_strobe = 1'b1; cyc(1);
        eoi_strobe = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; irq_lines = '0; irq_mask = '0; level_mode = 1'b0;
        auto_eoi = 1'b0; eoi_strobe = 1'b0; ack = 1'b0; vec_base = 5'b00011;
        cyc(3);
        check("R1 irr", irr_q, 8'h00);
        check("R1 isr", isr_q, 8'h00);
        check("R1 int_req", int_req, 1'b0);
        check("R1 data_oe", data_oe, 1'b0);
        rst = 1'b0; cyc(1);
    endtask

    task automatic t_edge_basic();
        irq_lines[6] = 1'b1; cyc(1);
        check("R2 edge capture", irr_q, 8'h40);
        check("R4 int_req raised", int_req, 1'b1);
        ack_first("edge", 8'h40, 8'h00);
        ack_second("edge", 8'h1E, 8'h40);
        cyc(3);
        check("R2 no recapture while high", irr_q, 8'h00);
        check("R9 isr held without eoi", isr_q, 8'h40);
        check("R10 same level no req", int_req, 1'b0);
        pulse_eoi();
        check("R9 eoi clears", isr_q, 8'h00);
        irq_lines[6] = 1'b0; cyc(1);
        irq_lines[6] = 1'b1; cyc(1);
        check("R2 fresh edge recaptured", irr_q, 8'h40);
        ack_first("edge2", 8'h40, 8'h00);
        ack_second("edge2", 8'h1E, 8'h40);
        pulse_eoi();
        irq_lines[6] = 1'b0; cyc(1);
    endtask

    task automatic t_nested();
        irq_lines[3] = 1'b1; cyc(1);
        ack_first("nest3", 8'h08, 8'h00);
        ack_second("nest3", 8'h1B, 8'h08);
        irq_lines[5] = 1'b1; cyc(1);
        check("R10 lower pending", irr_q, 8'h20);
        check("R10 lower no req", int_req, 1'b0);
        irq_lines[1] = 1'b1; cyc(1);
        check("R10 higher raises req", int_req, 1'b1);
        ack_first("nest1", 8'h0A, 8'h20);
        ack_second("nest1 R5", 8'h19, 8'h0A);
        pulse_eoi();
        check("R9 eoi clears lowest only", isr_q, 8'h08);
        check("R10 still blocked", int_req, 1'b0);
        pulse_eoi();
        check("R9 second eoi", isr_q, 8'h00);
        check("R4 unblocked req", int_req, 1'b1);
        auto_eoi = 1'b1;
        ack_first("nest5", 8'h20, 8'h00);
        ack_second("nest5 R8", 8'h1D, 8'h00);
        auto_eoi = 1'b0;
        irq_lines = '0; cyc(1);
    endtask

    task automatic t_mask_prio();
        irq_mask = 8'h04; irq_lines[2] = 1'b1; cyc(1);
        check("R4 masked pending", irr_q, 8'h04);
        check("R4 masked no req", int_req, 1'b0);
        irq_mask = 8'h00; cyc(1);
        check("R4 unmasked req", int_req, 1'b1);
        auto_eoi = 1'b1;
        ack_first("mask2", 8'h04, 8'h00);
        ack_second("mask2", 8'h1A, 8'h00);
        irq_lines = 8'h90; cyc(1);
        check("R5 both pending", irr_q, 8'h90);
        ack_first("prio4", 8'h10, 8'h80);
        ack_second("prio4 R5", 8'h1C, 8'h00);
        check("R4 remaining req", int_req, 1'b1);
        ack_first("prio7", 8'h80, 8'h00);
        ack_second("prio7", 8'h1F, 8'h00);
        auto_eoi = 1'b0;
        irq_lines = '0; cyc(1);
    endtask

    task automatic t_level();
        level_mode = 1'b1; auto_eoi = 1'b1; vec_base = 5'b10100;
        irq_lines[0] = 1'b1; cyc(1);
        check("R3 level follow", irr_q, 8'h01);
        ack_first("level", 8'h01, 8'h01);
        ack_second("level", 8'hA0, 8'h00);
        check("R3 irr kept while high", irr_q, 8'h01);
        irq_lines[0] = 1'b0; cyc(1);
        check("R3 irr drops with line", irr_q, 8'h00);
        check("R4 no req after drop", int_req, 1'b0);
        level_mode = 1'b0; auto_eoi = 1'b0;
    endtask

    initial begin
        t_reset();
        t_edge_basic();
        t_nested();
        t_mask_prio();
        t_level();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule